// File: doc/BRIEF.md
# Quarter-rate parallel configuration receiver

This block sits on the target side of an 8-bit parallel configuration port whose clock runs at four times the byte rate. The configuration clock edges are grouped in fours. The first edge of each group latches the byte bus and hands the byte to a downstream consumer, such as a decryptor or a decompressor. The three edges that follow are processing edges for that byte. Data content plays no part in the timing, so plain, encrypted and compressed streams are captured the same way.

The receiver counts delivered bytes against a programmed length. It raises a done flag once the last byte's three processing edges have elapsed. The clock may stop for any length of time. Only edges advance the group phase, so a pause never shifts the capture slot. An error reported from downstream produces an active-low status pulse, and so does a capture edge at which the consumer is not ready. The pulse lasts a fixed number of clock cycles. After it ends, the receiver restarts the load from the first byte. A configuration start input restarts the load at any time.

Top module: `cfg_qrate_rx`

## Requirements
- R1: While reset is asserted: status_no=1, valid_o=0, busy_o=0, done_o=0, ovr_o=0, count_o=0.
- R2: Bytes are captured on the first rising edge after reset release or after a start edge, and then on every fourth edge after that. valid_o is 1 for exactly the one cycle that follows a capture edge. During that cycle byte_o holds the data_i value sampled at that edge.
- R3: count_o rises by exactly one at each capture edge. It goes to 0 on a start edge and on entry to the error pulse.
- R4: busy_o is 1 during the three cycles after each capture edge and 0 in all other cycles.
- R5: Let k be the capture edge that makes count_o equal len_i. done_o becomes 1 at edge k+3, and no capture follows while done_o is 1. If len_i is 0, done_o becomes 1 at the first edge.
- R6: Suppose ready_i is 0 at a capture edge. Then no byte is delivered, ovr_o becomes 1 and the error pulse of R7 starts. ovr_o stays 1 until a start edge.
- R7: Suppose err_i is 1 at an edge outside the error pulse. Then status_no is 0 for exactly STATUS_CYC cycles, with no capture and busy_o at 0. The first edge after the pulse captures byte 1 of a fresh load.
- R8: A start edge (start_i=1 at an edge) has priority over everything else, including a running error pulse. It sets count_o=0, ovr_o=0, done_o=0 and status_no=1. The next edge is a capture edge.
- R9: Any pause of the clock leaves the group phase unchanged. Capture spacing is counted in edges only.
- R10: err_i is ignored while the error pulse is running. It does not extend the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock, may pause |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new configuration load |
| len_i | input | CNT_W | Expected byte count of the load |
| data_i | input | DATA_W | Parallel configuration byte bus |
| err_i | input | 1 | Downstream error report (e.g. wrong key) |
| ready_i | input | 1 | Downstream can accept a byte at this capture edge |
| byte_o | output | DATA_W | Captured byte |
| valid_o | output | 1 | byte_o carries a new byte this cycle |
| busy_o | output | 1 | Captured byte is still in its processing edges |
| done_o | output | 1 | Whole load received and processed |
| ovr_o | output | 1 | A capture edge met a consumer that was not ready |
| status_no | output | 1 | Active-low error status pulse |
| count_o | output | CNT_W | Bytes captured in the current load |

## Verification
The assertions check several properties on every cycle. A delivered byte is always one-cycle wide and always falls inside a busy window. The count changes only by a delivery or by a clear. Neither a delivery nor busy appears while the status pulse is low or while done is set. ovr_o is sticky, and a start always leaves a clean state behind it. Other behaviour needs the bench scenarios to show it: the exact edge on which done rises for each length, the exact pulse width, the restart after the pulse and the phase kept across a clock pause. The bench also runs a cycle model under random stimulus that mixes ready, error and start inputs.

// File: rtl/cfg_qrate_pkg.sv
package cfg_qrate_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DONE = 2'd1,
    ST_ERR  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/cfg_qrate_phase.sv
// Edge position inside the capture group; only clock edges move it.
module cfg_qrate_phase #(
  parameter int GROUP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic first_o,
  output logic last_o
);
  localparam int PH_W = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_q <= '0;
    else if (clr_i)         ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                    ph_q <= ph_q + 1'b1;
  end

  assign first_o = (ph_q == '0);
  assign last_o  = (ph_q == PH_LAST);
endmodule

// File: rtl/cfg_qrate_bytecnt.sv
module cfg_qrate_bytecnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_len_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o  = cnt_q;
  assign at_len_o = (cnt_q == len_i);
endmodule

// File: rtl/cfg_qrate_errpulse.sv
// Fixed-width status pulse; width counted in clock cycles.
module cfg_qrate_errpulse #(
  parameter int STATUS_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic active_o,
  output logic expired_o
);
  localparam int TMR_W = (STATUS_CYC > 2) ? $clog2(STATUS_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_INIT = TMR_W'(STATUS_CYC - 1);

  logic             act_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      tmr_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      tmr_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      tmr_q <= TMR_INIT;
    end else if (act_q) begin
      if (tmr_q == '0) act_q <= 1'b0;
      else             tmr_q <= tmr_q - 1'b1;
    end
  end

  assign active_o  = act_q;
  assign expired_o = act_q && (tmr_q == '0);
endmodule

// File: rtl/cfg_qrate_rx.sv
module cfg_qrate_rx
  import cfg_qrate_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int GROUP      = 4,
  parameter int STATUS_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              err_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovr_o,
  output logic              status_no,
  output logic [CNT_W-1:0]  count_o
);
  rx_state_e state_q, state_d;

  logic slot_first, slot_last, at_len;
  logic pulse_act, pulse_end;
  logic run, cap_edge, cap_ok, overrun, go_err, fin, ph_clr;

  assign run      = (state_q == ST_RUN);
  assign cap_edge = run && !start_i && !err_i && slot_first && !at_len;
  assign cap_ok   = cap_edge && ready_i;
  assign overrun  = cap_edge && !ready_i;
  assign go_err   = !start_i && (state_q != ST_ERR) && (err_i || overrun);
  // last byte finished on the final processing edge; len 0 finishes at once
  assign fin      = run && !start_i && !err_i && at_len && (slot_first || slot_last);
  assign ph_clr   = start_i || !run || go_err || fin;

  cfg_qrate_phase #(.GROUP(GROUP)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ph_clr),
    .first_o (slot_first),
    .last_o  (slot_last)
  );

  cfg_qrate_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i || go_err),
    .inc_i    (cap_ok),
    .len_i    (len_i),
    .count_o  (count_o),
    .at_len_o (at_len)
  );

  cfg_qrate_errpulse #(.STATUS_CYC(STATUS_CYC)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .load_i    (go_err),
    .active_o  (pulse_act),
    .expired_o (pulse_end)
  );

  always_comb begin
    state_d = state_q;
    if (start_i)                              state_d = ST_RUN;
    else if (go_err)                          state_d = ST_ERR;
    else if (fin)                             state_d = ST_DONE;
    else if (state_q == ST_ERR && pulse_end)  state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_o <= cap_ok;
      if (cap_ok)       byte_o <= data_i;
      if (start_i)      ovr_o  <= 1'b0;
      else if (overrun) ovr_o  <= 1'b1;
    end
  end

  assign busy_o    = run && !slot_first;
  assign done_o    = (state_q == ST_DONE);
  assign status_no = !pulse_act;
endmodule

// File: rtl/cfg_qrate_chk.sv
module cfg_qrate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             err_i,
  input logic             valid_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic             status_no,
  input logic [CNT_W-1:0] count_o
);
  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (valid_o || count_o == '0));

  p_valid_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o);

  p_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !valid_o));

  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_i && !start_i) |=> done_o);

  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !start_i) |=> ovr_o);

  p_ovr_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> !status_no);

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_no |-> (!valid_o && !busy_o && !done_o));

  p_start_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == '0 && status_no && !ovr_o && !done_o && !busy_o));
endmodule

bind cfg_qrate_rx cfg_qrate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .err_i     (err_i),
  .valid_o   (valid_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovr_o     (ovr_o),
  .status_no (status_no),
  .count_o   (count_o)
);

// File: tb/cfg_qrate_rx_tb.sv
module cfg_qrate_rx_tb;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int GRP = 4;
  localparam int SCYC = 16;

  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
  logic start = 1'b0, err = 1'b0, ready = 1'b1;
  logic [CW-1:0] len = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] byte_o;
  logic valid_o, busy_o, done_o, ovr_o, status_no;
  logic [CW-1:0] count_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0, cmp_en = 1'b0;

  cfg_qrate_rx #(.DATA_W(DW), .CNT_W(CW), .GROUP(GRP), .STATUS_CYC(SCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .data_i(data),
    .err_i(err), .ready_i(ready), .byte_o(byte_o), .valid_o(valid_o),
    .busy_o(busy_o), .done_o(done_o), .ovr_o(ovr_o), .status_no(status_no),
    .count_o(count_o));

  initial forever begin
    #(PERIOD/2);
    if (clk_en) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Reference cycle model built from the requirements: 0 run, 1 done, 2 pulse
  int m_st = 0, m_ph = 0, m_cnt = 0, m_tmr = 0;
  bit m_valid = 0, m_ovr = 0;
  int m_byte = 0;

  function automatic int exp_done_edge(input int l);
    return (l == 0) ? 1 : GRP * l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_cnt = 0; m_tmr = 0; m_valid = 0; m_ovr = 0; m_byte = 0;
    end else begin
      m_valid = 0;
      if (start) begin
        m_st = 0; m_ph = 0; m_cnt = 0; m_tmr = 0; m_ovr = 0;
      end else if (m_st == 0) begin
        if (err) begin
          m_st = 2; m_tmr = SCYC - 1; m_cnt = 0; m_ph = 0;
        end else if (m_ph == 0 && m_cnt != int'(len)) begin
          if (ready) begin
            m_byte = int'(data); m_valid = 1; m_cnt++; m_ph = 1;
          end else begin
            m_ovr = 1; m_st = 2; m_tmr = SCYC - 1; m_cnt = 0; m_ph = 0;
          end
        end else if (m_cnt == int'(len) && (m_ph == 0 || m_ph == GRP - 1)) begin
          m_st = 1; m_ph = 0;
        end else m_ph = (m_ph + 1) % GRP;
      end else if (m_st == 1) begin
        if (err) begin m_st = 2; m_tmr = SCYC - 1; m_cnt = 0; end
      end else begin
        if (m_tmr == 0) begin m_st = 0; m_ph = 0; end
        else m_tmr--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(status_no == (m_st != 2), "R7 status", status_no, m_st != 2);
      chk(valid_o == m_valid, "R2 valid", valid_o, m_valid);
      if (m_valid) chk(int'(byte_o) == m_byte, "R2 byte", byte_o, m_byte);
      chk(busy_o == (m_st == 0 && m_ph != 0), "R4 busy", busy_o, m_st == 0 && m_ph != 0);
      chk(done_o == (m_st == 1), "R5 done", done_o, m_st == 1);
      chk(int'(count_o) == m_cnt, "R3 count", count_o, m_cnt);
      chk(ovr_o == m_ovr, "R6 ovr", ovr_o, m_ovr);
    end
  end

  task automatic start_load(input int l);
    @(negedge clk);
    start = 1; len = CW'(l); err = 0; ready = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Directed: exact capture, busy and done edges for a given length
  task automatic run_len(input int l);
    start_load(l);
    data = DW'(8'hA0 + 1);
    for (int n = 1; n <= GRP * l + 4; n++) begin
      @(negedge clk);
      data = DW'(8'hA0 + n + 1);
      begin
        bit ev, eb, ed;
        ev = (n % GRP == 1) && (n <= GRP * l - 3);
        eb = (l > 0) && (n < GRP * l) && (n % GRP != 0);
        ed = (n >= exp_done_edge(l));
        chk(valid_o == ev, "R2 capture edge", valid_o, ev);
        if (ev) chk(byte_o == DW'(8'hA0 + n), "R2 byte value", byte_o, 8'hA0 + n);
        chk(busy_o == eb, "R4 busy window", busy_o, eb);
        chk(done_o == ed, "R5 done edge", done_o, ed);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    len = CW'(2); data = 8'h5C;
    #(PERIOD * 3 + 1);
    chk(status_no == 1 && valid_o == 0 && busy_o == 0 && done_o == 0 &&
        ovr_o == 0 && count_o == 0, "R1 reset state", {status_no, valid_o, busy_o}, 3'b100);
    @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    chk(valid_o == 1 && byte_o == 8'h5C, "R2 first edge after reset", byte_o, 8'h5C);

    run_len(3);
    run_len(1);
    run_len(0);
    run_len(5);

    // R7 / R10: pulse width, error during pulse ignored, restart
    begin
      int lows = 0;
      len = CW'(2);
      @(negedge clk); err = 1;
      @(negedge clk); err = 0;
      while (!status_no && lows < 100) begin
        lows++;
        err = (lows == 5);
        @(negedge clk);
      end
      err = 0;
      chk(lows == SCYC, "R7 R10 pulse width", lows, SCYC);
      @(negedge clk);
      chk(valid_o == 1 && count_o == 1, "R7 restart capture", count_o, 1);
    end

    // R6: overrun then sticky flag, cleared by start (R8)
    start_load(4);
    ready = 0;
    @(negedge clk);
    ready = 1;
    chk(ovr_o == 1 && valid_o == 0 && status_no == 0, "R6 overrun", {ovr_o, status_no}, 2'b10);
    repeat (SCYC + 3) @(negedge clk);
    chk(ovr_o == 1, "R6 ovr sticky", ovr_o, 1);
    start_load(4);
    chk(ovr_o == 0 && count_o == 0, "R8 start clears", ovr_o, 0);

    // R8: start aborts a running pulse
    @(negedge clk); err = 1;
    @(negedge clk); err = 0;
    repeat (3) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(status_no == 1 && count_o == 0, "R8 start ends pulse", status_no, 1);
    @(negedge clk);
    chk(valid_o == 1, "R8 next edge captures", valid_o, 1);

    // R9: long clock pause keeps the group phase
    start_load(3);
    @(negedge clk);
    chk(valid_o == 1, "R9 capture before pause", valid_o, 1);
    @(negedge clk);
    clk_en = 0;
    #(PERIOD * 50);
    clk_en = 1;
    @(negedge clk);
    chk(valid_o == 0, "R9 edge 3 after pause", valid_o, 0);
    @(negedge clk);
    chk(valid_o == 0, "R9 edge 4 after pause", valid_o, 0);
    @(negedge clk);
    chk(valid_o == 1, "R9 edge 5 captures", valid_o, 1);

    // Random mix against the cycle model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      data  = DW'($urandom);
      ready = ($urandom % 25) != 0;
      err   = ($urandom % 300) == 0;
      start = ($urandom % 150) == 0;
      if (start) len = CW'($urandom % 7);
    end
    @(negedge clk);
    start = 0; err = 0; ready = 1;
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end
endmodule